// File: doc/BRIEF.md
# Dual Reload Timer with Toggle Output

This block holds two free-running down-counters that share one register port. Each counter steps down by one on a single-cycle tick strobe. The strobe stands in for the timer clock that the surrounding system selects. When a tick arrives while a counter is at zero, the counter takes its reload value instead of stepping down. This event is an underflow, and it makes the period reload+1 ticks.

Underflows of the first counter can invert an output pin. Software sets the starting level of the pin, so a fixed reload value gives a square wave with 50% duty and needs no further software work. A pending flag records a low-to-high toggle of the pin; a high-to-low toggle does not set it. Every underflow of the second counter sets a second pending flag. Each flag drives a level interrupt request through its own enable bit. Software clears a flag by writing a one to its clear bit.

Register map: address 0 is reload A and address 1 is reload B. Address 2 is control: bit 0 runs counter A, bit 1 runs counter B, bit 2 enables pin toggling, bit 3 enables interrupt A, and bit 4 enables interrupt D. Address 3 holds the pin level in bit 0. At address 4, a read returns the flags (bit 0 is flag A, bit 1 is flag D) and a write of one to a bit clears that flag. Addresses 5 and 6 read counter A and counter B.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the reload registers, the counters, the control register and both flags read zero, pin_out equals the PIN_INIT parameter (default 0), and both interrupt outputs are low.
- R2: A tick on a running counter that holds a nonzero value lowers it by one. Without a tick, or with its run bit clear, the counter holds its value.
- R3: A tick on a running counter that holds zero loads the reload value, so the period is reload+1 ticks.
- R4: A write to a reload register (address 0 or 1) also loads that value into its counter at the same clock edge.
- R5: With the toggle enable (control bit 2) set, pin_out inverts on every underflow of counter A. With it clear, pin_out keeps its level across underflows.
- R6: A write to address 3 sets pin_out to wr_data bit 0 and leaves the pending flags unchanged.
- R7: Only a low-to-high toggle of pin_out sets flag A (bit 0 at address 4). A high-to-low toggle leaves it unchanged.
- R8: Every underflow of counter B sets flag D (bit 1 at address 4). Counter B ignores tick_a, and its count is unaffected by counter A.
- R9: Writing one to a bit at address 4 clears that flag. If a set event falls in the same cycle as the clear, the flag ends up set.
- R10: irq_a is high exactly while flag A and interrupt enable A (control bit 3) are both set, and irq_d likewise with flag D and control bit 4.
- R11: With reload N and a tick every cycle, pin_out stays at each level for N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count strobe for counter A |
| tick_b | input | 1 | Count strobe for counter B |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data for addr (combinational) |
| pin_out | output | 1 | Toggle output pin |
| irq_a | output | 1 | Interrupt request for pin rising toggles |
| irq_d | output | 1 | Interrupt request for counter B underflows |

## Verification
The counters are driven four ways: with no ticks, with ticks while stopped, with ticks across zero, and with a continuous tick. These cases separate a plain decrement from the reload at zero and from a counter that ignores its run bit. The pin is toggled in both directions with toggling enabled and disabled, and each case is followed by a flag read, so a flag set on the falling toggle or a pin that ignores the enable can be seen. Counter B runs while only tick_a strobes, which shows that the two channels are kept apart. A flag clear is written in the same cycle as an underflow to test which of the two wins. Finally, a continuous square-wave run is checked edge by edge against the reload+1 period.

// File: rtl/drt_pkg.sv
package drt_pkg;

   localparam int ADDR_W = 3;
   localparam int NUM_CH = 2;
   localparam int NUM_FLAGS = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_RELOAD_A = 3'd0,
      REG_RELOAD_B = 3'd1,
      REG_CTRL     = 3'd2,
      REG_PIN      = 3'd3,
      REG_FLAGS    = 3'd4,
      REG_COUNT_A  = 3'd5,
      REG_COUNT_B  = 3'd6
   } reg_addr_e;

   localparam int CTRL_W = 5;

   typedef struct packed {
      logic ien_d;
      logic ien_a;
      logic pin_en;
      logic run_b;
      logic run_a;
   } ctrl_t;

   localparam int FLAG_A = 0;
   localparam int FLAG_D = 1;

endpackage

// File: rtl/drt_counter.sv
module drt_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic [WIDTH-1:0] reload,
   output logic [WIDTH-1:0] count,
   output logic             underflow
);

   logic [WIDTH-1:0] cnt_q;
   logic             at_zero;
   logic             step;

   assign at_zero   = (cnt_q == '0);
   assign step      = run & tick;
   assign underflow = step & at_zero & ~load;
   assign count     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         if (at_zero) cnt_q <= reload;
         else         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/drt_toggle_pin.sv
module drt_toggle_pin #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic preset_we,
   input  logic preset_val,
   input  logic toggle_en,
   input  logic underflow,
   output logic pin,
   output logic rise
);

   logic pin_q;
   logic flip;

   assign flip = toggle_en & underflow & ~preset_we;
   assign rise = flip & ~pin_q;
   assign pin  = pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pin_q <= INIT;
      else if (preset_we) pin_q <= preset_val;
      else if (flip)      pin_q <= ~pin_q;
   end

endmodule

// File: rtl/drt_pending.sv
module drt_pending #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_q <= 1'b0;
         else if (set[i]) flag_q <= 1'b1;
         else if (clr[i]) flag_q <= 1'b0;
      end
      assign pend[i] = flag_q;
   end

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
   import drt_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter bit PIN_INIT = 1'b0,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_a,
   input  logic             tick_b,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   output logic             pin_out,
   output logic             irq_a,
   output logic             irq_d
);

   if (WIDTH < CTRL_W || WIDTH > 32) begin : g_bad_width
      $error("dual_reload_timer: WIDTH must lie in 5..32");
   end

   localparam logic [WIDTH-1:0] ZERO_W = '0;

   ctrl_t            ctrl_q;
   logic [WIDTH-1:0] reload_q [NUM_CH];
   logic [WIDTH-1:0] cnt_v    [NUM_CH];
   logic [NUM_CH-1:0] uf_v;
   logic [NUM_CH-1:0] run_v;
   logic [NUM_CH-1:0] tick_v;
   logic [NUM_CH-1:0] load_v;

   logic [WIDTH-1:0] reload_a, cnt_a, cnt_b;
   logic             uf_a, uf_b, run_a, pin_en;
   logic             wr_ctrl, wr_pin, wr_flags;
   logic             pin_rise;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, pend;

   assign wr_ctrl  = wr_en && (addr == REG_CTRL);
   assign wr_pin   = wr_en && (addr == REG_PIN);
   assign wr_flags = wr_en && (addr == REG_FLAGS);

   assign run_v  = {ctrl_q.run_b, ctrl_q.run_a};
   assign tick_v = {tick_b, tick_a};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [2:0] RELOAD_ADDR = (c == 0) ? REG_RELOAD_A : REG_RELOAD_B;

      assign load_v[c] = wr_en && (addr == RELOAD_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         reload_q[c] <= '0;
         else if (load_v[c]) reload_q[c] <= wr_data;
      end

      drt_counter #(.WIDTH(WIDTH)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run_v[c]),
         .tick      (tick_v[c]),
         .load      (load_v[c]),
         .load_val  (wr_data),
         .reload    (reload_q[c]),
         .count     (cnt_v[c]),
         .underflow (uf_v[c])
      );
   end

   assign reload_a = reload_q[0];
   assign cnt_a    = cnt_v[0];
   assign cnt_b    = cnt_v[1];
   assign uf_a     = uf_v[0];
   assign uf_b     = uf_v[1];
   assign run_a    = ctrl_q.run_a;
   assign pin_en   = ctrl_q.pin_en;

   drt_toggle_pin #(.INIT(PIN_INIT)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .preset_we  (wr_pin),
      .preset_val (wr_data[0]),
      .toggle_en  (pin_en),
      .underflow  (uf_a),
      .pin        (pin_out),
      .rise       (pin_rise)
   );

   assign flag_set[FLAG_A] = pin_rise;
   assign flag_set[FLAG_D] = uf_b;
   assign flag_clr         = wr_flags ? wr_data[NUM_FLAGS-1:0] : '0;

   drt_pending #(.N(NUM_FLAGS)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .pend  (pend)
   );

   logic irq_a_c, irq_d_c;
   assign irq_a_c = pend[FLAG_A] & ctrl_q.ien_a;
   assign irq_d_c = pend[FLAG_D] & ctrl_q.ien_d;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_a_q, irq_d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_a_q <= 1'b0;
            irq_d_q <= 1'b0;
         end else begin
            irq_a_q <= irq_a_c;
            irq_d_q <= irq_d_c;
         end
      end
      assign irq_a = irq_a_q;
      assign irq_d = irq_d_q;
   end else begin : g_irq_comb
      assign irq_a = irq_a_c;
      assign irq_d = irq_d_c;
   end

   always_comb begin
      rd_data = ZERO_W;
      case (addr)
         REG_RELOAD_A: rd_data = reload_q[0];
         REG_RELOAD_B: rd_data = reload_q[1];
         REG_CTRL:     rd_data[CTRL_W-1:0] = ctrl_q;
         REG_PIN:      rd_data[0] = pin_out;
         REG_FLAGS:    rd_data[NUM_FLAGS-1:0] = pend;
         REG_COUNT_A:  rd_data = cnt_v[0];
         REG_COUNT_B:  rd_data = cnt_v[1];
         default:      rd_data = ZERO_W;
      endcase
   end

endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       addr,
   input logic             wr_bit0,
   input logic             tick_a,
   input logic             run_a,
   input logic             pin_en,
   input logic [WIDTH-1:0] cnt_a,
   input logic [WIDTH-1:0] reload_a,
   input logic             uf_a,
   input logic             uf_b,
   input logic             pin_out,
   input logic             pend_a,
   input logic             pend_d
);

   logic wr_rel_a, wr_pin, wr_flags;
   assign wr_rel_a = wr_en && (addr == 3'd0);
   assign wr_pin   = wr_en && (addr == 3'd3);
   assign wr_flags = wr_en && (addr == 3'd4);

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_a && tick_a && (cnt_a != '0) && !wr_rel_a) |=> (cnt_a == $past(cnt_a) - 1'b1));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run_a && tick_a) && !wr_rel_a) |=> $stable(cnt_a));

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      uf_a |=> (cnt_a == $past(reload_a)));

   assert_pin_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(uf_a && pin_en) && !wr_pin) |=> $stable(pin_out));

   assert_rise_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_a) |-> (pin_out && !$past(pin_out)));

   assert_pend_d_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uf_b |=> pend_d);

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flags && wr_bit0 && !(uf_a && pin_en && !pin_out)) |=> !pend_a);

endmodule

bind dual_reload_timer drt_checker #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wr_bit0  (wr_data[0]),
   .tick_a   (tick_a),
   .run_a    (run_a),
   .pin_en   (pin_en),
   .cnt_a    (cnt_a),
   .reload_a (reload_a),
   .uf_a     (uf_a),
   .uf_b     (uf_b),
   .pin_out  (pin_out),
   .pend_a   (pend[0]),
   .pend_d   (pend[1])
);

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_a = 1'b0, tick_b = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   addr = 3'd0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         pin_out, irq_a, irq_d;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_reload_timer #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .pin_out(pin_out), .irq_a(irq_a), .irq_d(irq_d)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic tick(input logic a, input logic b, input int n);
      tick_a = a; tick_b = b;
      repeat (n) @(negedge clk);
      tick_a = 1'b0; tick_b = 1'b0;
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      chk("R1 pin", pin_out, 0);
      chk("R1 irq_a", irq_a, 0);
      chk("R1 irq_d", irq_d, 0);
      for (int a = 0; a < 7; a++) begin
         rd(a[2:0], v);
         chk("R1 reg", v, 0);
      end
   endtask

   task automatic t_count();
      logic [W-1:0] v;
      wr(3'd0, 16'd5);
      rd(3'd5, v); chk("R4 load on reload write", v, 5);
      wr(3'd2, 16'h0001);
      repeat (3) @(negedge clk);
      rd(3'd5, v); chk("R2 hold without tick", v, 5);
      tick(1, 0, 3);
      rd(3'd5, v); chk("R2 decrement", v, 2);
      wr(3'd2, 16'h0000);
      tick(1, 0, 2);
      rd(3'd5, v); chk("R2 stopped holds", v, 2);
   endtask

   task automatic t_reload();
      logic [W-1:0] v;
      wr(3'd0, 16'd3);
      wr(3'd2, 16'h0001);
      tick(1, 0, 3);
      rd(3'd5, v); chk("R3 reaches zero", v, 0);
      tick(1, 0, 1);
      rd(3'd5, v); chk("R3 reload at zero", v, 3);
      chk("R5 pin held while disabled", pin_out, 0);
   endtask

   task automatic t_toggle();
      logic [W-1:0] v;
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'd1);
      wr(3'd3, 16'd0);
      wr(3'd2, 16'd13);
      tick(1, 0, 2);
      chk("R5 pin rises on underflow", pin_out, 1);
      rd(3'd4, v); chk("R7 rise sets flag A", v, 1);
      chk("R10 irq_a", irq_a, 1);
      wr(3'd4, 16'd1);
      rd(3'd4, v); chk("R9 clear flag A", v, 0);
      tick(1, 0, 2);
      chk("R5 pin falls on underflow", pin_out, 0);
      rd(3'd4, v); chk("R7 fall leaves flag", v, 0);
      chk("R10 irq_a low", irq_a, 0);
      wr(3'd2, 16'd9);
      tick(1, 0, 2);
      chk("R5 toggle disabled holds", pin_out, 0);
      rd(3'd5, v); chk("R3 count after reload", v, 1);
      rd(3'd4, v); chk("R7 no flag when disabled", v, 0);
   endtask

   task automatic t_pin_write();
      logic [W-1:0] v;
      wr(3'd3, 16'd1);
      chk("R6 pin preset high", pin_out, 1);
      rd(3'd4, v); chk("R6 no flag from preset", v, 0);
      wr(3'd3, 16'd0);
      chk("R6 pin preset low", pin_out, 0);
   endtask

   task automatic t_irq_mask();
      logic [W-1:0] v;
      wr(3'd2, 16'd5);
      tick(1, 0, 2);
      rd(3'd4, v); chk("R7 flag set", v, 1);
      chk("R10 masked irq_a", irq_a, 0);
      wr(3'd2, 16'd13);
      chk("R10 unmask irq_a", irq_a, 1);
      wr(3'd4, 16'd1);
      chk("R10 irq_a after clear", irq_a, 0);
      wr(3'd2, 16'd0);
   endtask

   task automatic t_counter_b();
      logic [W-1:0] v;
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd18);
      tick(1, 0, 5);
      rd(3'd6, v); chk("R8 ignores tick_a", v, 2);
      rd(3'd4, v); chk("R8 no flag D yet", v, 0);
      tick(0, 1, 3);
      rd(3'd4, v); chk("R8 underflow sets flag D", v, 2);
      chk("R10 irq_d", irq_d, 1);
      rd(3'd6, v); chk("R3 counter B reload", v, 2);
      wr(3'd4, 16'd2);
      rd(3'd4, v); chk("R9 clear flag D", v, 0);
      chk("R10 irq_d low", irq_d, 0);
      tick(0, 1, 3);
      rd(3'd4, v); chk("R8 second underflow", v, 2);
      wr(3'd4, 16'd2);
   endtask

   task automatic t_clear_race();
      logic [W-1:0] v;
      wr(3'd1, 16'd0);
      tick_b = 1'b1; wr_en = 1'b1; addr = 3'd4; wr_data = 16'd2;
      @(negedge clk);
      tick_b = 1'b0; wr_en = 1'b0; wr_data = '0;
      rd(3'd4, v); chk("R9 set wins over clear", v, 2);
      wr(3'd4, 16'd2);
      rd(3'd4, v); chk("R9 clear after race", v, 0);
      wr(3'd2, 16'd0);
   endtask

   task automatic t_square();
      wr(3'd0, 16'd2);
      wr(3'd3, 16'd0);
      wr(3'd2, 16'd5);
      tick_a = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         chk("R11 square wave", pin_out, (k / 3) % 2);
      end
      tick_a = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_reload();
      t_toggle();
      t_pin_write();
      t_irq_mask();
      t_counter_b();
      t_clear_race();
      t_square();
      finish_run();
   end

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

endmodule